// File: doc/BRIEF.md
# Line-Card Serial Command and Status Port

This block sits between a card microcontroller and a telephone line interface. The controller uses five pins to reach it: a serial clock, a bidirectional data pin, a direction select, an active-low chip select, and a chip-select-mode pin. A write shifts an 8-bit command into a holding register, least significant bit first. That word becomes the active command only when chip select is released. A read shifts out a snapshot of five line status bits, bit 0 first. The controller may stop a read early.

The active command drives the rest of the line card. The block decodes it into a line current limit in milliamperes and a line state code. When the chip-select-mode pin is high, the chip-select pin becomes an output that flags any pending hook or ground-key event. A parallel strap bypasses every register. Three input pins then act directly as the feed, timing and ring command bits, and the chip-select and data pins report hook and ground-key status live.

All five controller pins are asynchronous to the system clock. Each passes through a two-stage synchronizer, and serial clock and chip select edges are detected in the system clock domain. A pin change therefore takes effect within four system clock cycles.

Top module: `line_ctl_port`

## Requirements
- R1: After reset the active command is 0x00, line_mode is 0 (denial), ilim_ma is 25, and neither the data pin nor the chip-select pin is driven (dat_oe = 0, cs_n_oe = 0).
- R2: In serial mode, with dir_rd = 0, cs_mode = 0 and cs_n_i = 0, dat_i is sampled on each rising sck. The first sampled bit becomes command bit 0, and eight clocks form a full word.
- R3: The shifted word is copied to cmd_o only on the rising edge of cs_n_i. While chip select stays low, cmd_o keeps its previous value.
- R4: A write released after fewer than 8 clocks leaves cmd_o unchanged. A write of more than 8 clocks commits the last 8 bits sampled, the earliest of those eight becoming bit 0.
- R5: In a read (dir_rd = 1, cs_n_i low), the status is captured when chip select falls. dat_o presents status bit 0 first and moves to the next bit on each rising sck. After all 5 bits it shows 0. Later changes of stat_i do not alter the bits being shifted.
- R6: A read may end after fewer than 5 bits. Releasing chip select then stops driving dat_o, and a read of any length leaves cmd_o unchanged.
- R7: In serial mode, dat_oe is 1 only while cs_mode = 0, chip select is low and dir_rd = 1. During a write the data pin is never driven.
- R8: When cs_mode = 1 in serial mode, cs_n_oe = 1 and cs_n_o = stat_i[0] OR stat_i[1]. Serial transfers are ignored and leave cmd_o unchanged.
- R9: The current limit is decoded from the pair (bit6, bit7) of the active command: (0,0) = 25, (0,1) = 30, (1,1) = 45, (1,0) = 70 mA on ilim_ma.
- R10: In serial mode line_mode is 2 (conversation) when bit0 = 1. It is 3 (ringing) when bit0 = 0, bit2 = 1 and any of bits 5 to 7 is set. It is 1 (stand-by) when bit0 = 0, it is not ringing, and bit6 or bit7 is set. Otherwise it is 0 (denial), which includes the all-zero command.
- R11: With par_mode = 1, cmd_o = {5'b0, sck, cs_mode, dir_rd}, that is bit0 from dir_rd, bit1 from cs_mode and bit2 from sck. ilim_ma is 30. line_mode is 2 when bit0 = 1, otherwise 3 when bit2 = 1, otherwise 1.
- R12: With par_mode = 1, both pins are driven (cs_n_oe = 1, dat_oe = 1): cs_n_o carries stat_i[0] (hook) and dat_o carries stat_i[1] (ground key).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 1 | Static strap: 1 selects parallel mode |
| sck | input | 1 | Serial clock; ring command pin in parallel mode |
| dir_rd | input | 1 | Direction select (1 = read); feed command pin in parallel mode |
| cs_n_i | input | 1 | Active-low chip select input |
| cs_mode | input | 1 | 1 turns chip select into an output; timing command pin in parallel mode |
| dat_i | input | 1 | Data pin input value |
| stat_i | input | 5 | Line status: bit0 hook, bit1 ground key, bits 2 to 4 other status |
| cs_n_o | output | 1 | Chip-select pin output value |
| cs_n_oe | output | 1 | Chip-select pin output enable |
| dat_o | output | 1 | Data pin output value |
| dat_oe | output | 1 | Data pin output enable |
| cmd_o | output | 8 | Active command word |
| ilim_ma | output | 7 | Decoded line current limit in mA |
| line_mode | output | 2 | 0 denial, 1 stand-by, 2 conversation, 3 ringing |

## Verification
The bench writes every one of the 256 command words and checks the committed word, the decoded current limit and the decoded line state against arithmetic in the bench. A swapped bit order, a wrong pairing of bits 6 and 7, or a mode decoder that lets ringing win without bits 5 to 7 set would each show up as a mismatch on many of these words. It also reads all 32 status values while changing stat_i after chip select falls. A design that shifts live status instead of a snapshot, or that does not fill with zero after the fifth bit, would put the wrong value on dat_o. Aborted writes, over-long writes, a held chip select, writes while chip select is an output, and a sweep of the parallel pins target a commit on the wrong edge or on a partial word, and a mode bypass that still uses the registers.

// File: rtl/line_ctl_port.sv
module line_ctl_port #(
  parameter int CMD_W  = 8,
  parameter int STAT_W = 5,
  parameter int SYNC_N = 2,
  parameter int ILIM_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              sck,
  input  logic              dir_rd,
  input  logic              cs_n_i,
  input  logic              cs_mode,
  input  logic              dat_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              cs_n_o,
  output logic              cs_n_oe,
  output logic              dat_o,
  output logic              dat_oe,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ILIM_W-1:0] ilim_ma,
  output logic [1:0]        line_mode
);

  localparam int PIN_N = 5;
  localparam int CNT_W = $clog2(CMD_W + 1);
  localparam logic [PIN_N-1:0] PIN_RST = 5'b01000;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CMD_W);

  logic [SYNC_N-1:0][PIN_N-1:0] sync_q;
  logic [PIN_N-1:0] pins, pin_s;
  logic sck_s, dat_s, dir_s, cs_s, csm_s;
  logic sck_q, cs_q;
  logic sel, sck_rise, cs_fall, cs_rise;
  logic [CMD_W-1:0]  wr_sh, cmd_q, par_cmd;
  logic [CNT_W-1:0]  wr_cnt;
  logic [STAT_W-1:0] rd_sh;
  logic lim_nz, ext_nz;

  assign pins = {cs_mode, cs_n_i, dir_rd, dat_i, sck};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= {SYNC_N{PIN_RST}};
    else        sync_q <= {sync_q[SYNC_N-2:0], pins};

  assign pin_s = sync_q[SYNC_N-1];
  assign sck_s = pin_s[0];
  assign dat_s = pin_s[1];
  assign dir_s = pin_s[2];
  assign cs_s  = pin_s[3];
  assign csm_s = pin_s[4];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
    end

  assign sel      = !par_mode && !csm_s && !cs_s;
  assign sck_rise = sck_s && !sck_q;
  assign cs_fall  = !par_mode && !csm_s && !cs_s && cs_q;
  assign cs_rise  = !par_mode && !csm_s && cs_s && !cs_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sh  <= '0;
      wr_cnt <= '0;
      rd_sh  <= '0;
    end else if (cs_fall) begin
      wr_cnt <= '0;
      rd_sh  <= stat_i;
    end else if (sel && sck_rise) begin
      if (dir_s) begin
        rd_sh <= rd_sh >> 1;
      end else begin
        wr_sh <= {dat_s, wr_sh[CMD_W-1:1]};
        if (wr_cnt != FULL) wr_cnt <= wr_cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cmd_q <= '0;
    else if (cs_rise && !dir_s && wr_cnt == FULL) cmd_q <= wr_sh;

  assign par_cmd = CMD_W'({sck_s, csm_s, dir_s});
  assign cmd_o   = par_mode ? par_cmd : cmd_q;

  always_comb begin
    if (par_mode) ilim_ma = ILIM_W'(30);
    else begin
      case ({cmd_q[6], cmd_q[7]})
        2'b00:   ilim_ma = ILIM_W'(25);
        2'b01:   ilim_ma = ILIM_W'(30);
        2'b11:   ilim_ma = ILIM_W'(45);
        default: ilim_ma = ILIM_W'(70);
      endcase
    end
  end

  assign lim_nz = par_mode || (|cmd_o[7:6]);
  assign ext_nz = par_mode || (|cmd_o[7:5]);

  always_comb begin
    if (cmd_o[0])                line_mode = 2'd2;
    else if (cmd_o[2] && ext_nz) line_mode = 2'd3;
    else if (lim_nz)             line_mode = 2'd1;
    else                         line_mode = 2'd0;
  end

  assign cs_n_oe = par_mode || csm_s;
  assign cs_n_o  = par_mode ? stat_i[0] : (stat_i[0] | stat_i[1]);
  assign dat_oe  = par_mode || (sel && dir_s);
  assign dat_o   = par_mode ? stat_i[1] : rd_sh[0];

endmodule

// File: rtl/line_ctl_port_chk.sv
module line_ctl_port_chk #(
  parameter int CMD_W  = 8,
  parameter int STAT_W = 5,
  parameter int ILIM_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              par_mode,
  input logic              dir_s,
  input logic              cs_rise,
  input logic [STAT_W-1:0] stat_i,
  input logic              cs_n_o,
  input logic              cs_n_oe,
  input logic              dat_oe,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [ILIM_W-1:0] ilim_ma,
  input logic [1:0]        line_mode
);

  AST_CMD_ONLY_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && $past(!par_mode) && !$past(cs_rise)) |-> $stable(cmd_o)); // R3

  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !dir_s) |-> !dat_oe); // R7

  AST_CS_FLAG_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && cs_n_oe && (stat_i[1:0] != 2'b00)) |-> cs_n_o); // R8

  AST_PAR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> (ilim_ma == ILIM_W'(30))); // R11

  AST_PAR_PINS_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |-> (dat_oe && cs_n_oe)); // R12

  AST_ZERO_IS_DENIAL: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && cmd_o == '0) |-> (line_mode == 2'd0)); // R10

endmodule

bind line_ctl_port line_ctl_port_chk #(.CMD_W(CMD_W), .STAT_W(STAT_W), .ILIM_W(ILIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .dir_s(dir_s), .cs_rise(cs_rise),
  .stat_i(stat_i), .cs_n_o(cs_n_o), .cs_n_oe(cs_n_oe), .dat_oe(dat_oe),
  .cmd_o(cmd_o), .ilim_ma(ilim_ma), .line_mode(line_mode)
);

// File: tb/line_ctl_port_bench.sv
module line_ctl_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic par_mode = 1'b0, sck = 1'b0, dir_rd = 1'b0, cs_n_i = 1'b1, cs_mode = 1'b0, dat_i = 1'b0;
  logic [4:0] stat_i = '0;
  logic cs_n_o, cs_n_oe, dat_o, dat_oe;
  logic [7:0] cmd_o;
  logic [6:0] ilim_ma;
  logic [1:0] line_mode;

  int vectors = 0;
  int fails = 0;
  logic [7:0] exp_cmd = '0;

  always #2.5 clk = ~clk;

  line_ctl_port u_line_ctl_port (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .sck(sck), .dir_rd(dir_rd),
    .cs_n_i(cs_n_i), .cs_mode(cs_mode), .dat_i(dat_i), .stat_i(stat_i),
    .cs_n_o(cs_n_o), .cs_n_oe(cs_n_oe), .dat_o(dat_o), .dat_oe(dat_oe),
    .cmd_o(cmd_o), .ilim_ma(ilim_ma), .line_mode(line_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    repeat (6) @(negedge clk);
  endtask

  function automatic int lim_of(input logic [7:0] c);
    case ({c[6], c[7]})
      2'b00: return 25;
      2'b01: return 30;
      2'b11: return 45;
      default: return 70;
    endcase
  endfunction

  function automatic int mode_of(input logic [7:0] c, input logic par);
    if (c[0]) return 2;
    if (par) return c[2] ? 3 : 1;
    if (c[2] && (c[7:5] != 0)) return 3;
    if (c[7:6] != 0) return 1;
    return 0;
  endfunction

  task automatic shift_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      dat_i = v[i]; step();
      sck = 1'b1; step();
      sck = 1'b0; step();
    end
  endtask

  task automatic wr(input logic [15:0] v, input int n);
    dir_rd = 1'b0; cs_n_i = 1'b0; step();
    shift_bits(v, n);
    cs_n_i = 1'b1; step();
  endtask

  task automatic rd(input logic [4:0] s, input int n);
    stat_i = s; dir_rd = 1'b1; cs_n_i = 1'b0; step();
    stat_i = ~s;
    chk("R5 read drive", int'(dat_oe), 1);
    chk("R5 read bit0", int'(dat_o), int'(s[0]));
    for (int k = 1; k <= n; k++) begin
      sck = 1'b1; step();
      chk("R5 read bit", int'(dat_o), (k < 5) ? int'(s[k]) : 0);
      sck = 1'b0; step();
    end
    cs_n_i = 1'b1; step();
    chk("R6 release hi-z", int'(dat_oe), 0);
    chk("R6 cmd kept", int'(cmd_o), int'(exp_cmd));
    dir_rd = 1'b0; step();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    step();
    chk("R1 cmd", int'(cmd_o), 0);
    chk("R1 mode", int'(line_mode), 0);
    chk("R1 ilim", int'(ilim_ma), 25);
    chk("R1 dat_oe", int'(dat_oe), 0);
    chk("R1 cs_n_oe", int'(cs_n_oe), 0);

    for (int c = 0; c < 256; c++) begin
      wr(16'(c), 8);
      exp_cmd = 8'(c);
      chk("R2 cmd", int'(cmd_o), c);
      chk("R9 ilim", int'(ilim_ma), lim_of(8'(c)));
      chk("R10 mode", int'(line_mode), mode_of(8'(c), 1'b0));
    end

    wr(16'h00A5, 8); exp_cmd = 8'hA5;
    dir_rd = 1'b0; cs_n_i = 1'b0; step();
    shift_bits(16'h003C, 8);
    chk("R7 no drive on write", int'(dat_oe), 0);
    chk("R3 held until release", int'(cmd_o), 8'hA5);
    cs_n_i = 1'b1; step();
    exp_cmd = 8'h3C;
    chk("R3 commit at release", int'(cmd_o), 8'h3C);

    wr(16'h00FF, 5);
    chk("R4 short write ignored", int'(cmd_o), int'(exp_cmd));
    wr(16'h0000, 7);
    chk("R4 seven bits ignored", int'(cmd_o), int'(exp_cmd));
    wr(16'h02D4, 10);
    exp_cmd = 8'hB5;
    chk("R4 long write last eight", int'(cmd_o), 8'hB5);

    for (int s = 0; s < 32; s++) rd(5'(s), 6);
    rd(5'b10110, 2);
    rd(5'b00001, 0);

    cs_mode = 1'b1; step();
    for (int s = 0; s < 4; s++) begin
      stat_i = 5'(s); step();
      chk("R8 cs output enable", int'(cs_n_oe), 1);
      chk("R8 cs output value", int'(cs_n_o), (s != 0) ? 1 : 0);
    end
    wr(16'h0011, 8);
    chk("R8 write ignored", int'(cmd_o), int'(exp_cmd));
    dir_rd = 1'b1; cs_n_i = 1'b0; step();
    chk("R8 read ignored", int'(dat_oe), 0);
    cs_n_i = 1'b1; dir_rd = 1'b0; cs_mode = 1'b0; step();

    par_mode = 1'b1;
    for (int p = 0; p < 8; p++) begin
      dir_rd = p[0]; cs_mode = p[1]; sck = p[2];
      stat_i = 5'(p * 3);
      step();
      chk("R11 par cmd", int'(cmd_o), p);
      chk("R11 par ilim", int'(ilim_ma), 30);
      chk("R11 par mode", int'(line_mode), mode_of(8'(p), 1'b1));
      chk("R12 hook on cs", int'(cs_n_o), int'(stat_i[0]));
      chk("R12 gk on data", int'(dat_o), int'(stat_i[1]));
      chk("R12 driven", int'(dat_oe & cs_n_oe), 1);
    end
    dir_rd = 1'b0; cs_mode = 1'b0; sck = 1'b0;
    par_mode = 1'b0; step();
    chk("R11 serial word restored", int'(cmd_o), int'(exp_cmd));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule